// File: doc/BRIEF.md
# Differential Clock Output Gating Controller

This block gates the eight outputs of a differential clock fan-out. Each output has a true and a complement wire, and each wire is modelled as a digital level plus a drive-enable flag, so that an undriven wire is visible as a state. All eight outputs are driven from one internal output clock. That clock toggles on every edge of `clk`, so one output period spans two `clk` cycles. A "complement rising edge" is a `clk` edge on which the true level goes low and the complement goes high.

Three controls act on the outputs. The first is a per-output enable, whose polarity a strap selects. The second is a global active-low stop, which affects only the outputs marked stoppable. The third is a global active-low power-down, which affects every output. Stop and power-down are each accepted only after two matching samples on consecutive complement rising edges. Every change of an output is aligned to the clock phase, so no pulse is shortened. After a release, the parked outputs wait a fixed number of output periods and then resume together. Drive-mode inputs choose how a parked output is left for stop and for power-down.

Top module: `diff_clk_gate`

## Requirements
- R1: While `rst` is high, every output is driven with true=0 and complement=1. After reset, every enabled output toggles on every `clk` cycle, with complement equal to the inverse of true.
- R2: A change of `stop_n` is accepted only when it reads the same value at two consecutive complement rising edges. A low pulse one `clk` cycle long has no effect on any output.
- R3: With `stop_mode`=0, an accepted stop parks each stoppable output after its next transition. The parked output has true driven high and the complement undriven at level 0, and it stays static while parked.
- R4: With `stop_mode`=1, an accepted stop parks each stoppable output with both true and complement undriven at level 0.
- R5: An output whose `stop_en` bit is 0 keeps toggling while stop is asserted.
- R6: After `stop_n` returns high, all stopped outputs start driving their complement again in the same cycle. This happens 6 to 16 `clk` cycles after the release: 3 output periods after the release is accepted, plus phase alignment.
- R7: A `pd_n` low that is accepted on two consecutive complement rising edges parks every output, stoppable or not, at the next true rising phase. With `pd_mode`=0, true is driven high and the complement is undriven. A one-cycle low pulse is ignored.
- R8: With `pd_mode`=1, power-down leaves both true and complement of every output undriven at level 0.
- R9: After `pd_n` is released, every output resumes toggling.
- R10: Output i is enabled when `oe_in[i]` XOR the captured strap is 1: with strap 0 the enables are active high, with strap 1 they are active low. A disabled output parks as a stopped output does, in the current `stop_mode`.
- R11: `oe_pol_strap` is captured only while `rst` is high. A later change of the strap has no effect on the outputs.
- R12: An undriven wire always reads level 0. A complement is driven only while its true wire is driven and carries the inverse level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, twice the output clock rate |
| rst | input | 1 | Synchronous active-high reset |
| oe_pol_strap | input | 1 | Enable polarity strap, captured during reset |
| oe_in | input | N_OUT | Per-output enables |
| stop_n | input | 1 | Global stop request, active low |
| pd_n | input | 1 | Power-down request, active low |
| stop_en | input | N_OUT | Per-output bit: 1 = obeys stop, 0 = free-running |
| stop_mode | input | 1 | Parked drive for stop and disable: 0 true high, 1 all undriven |
| pd_mode | input | 1 | Parked drive for power-down: 0 true high, 1 all undriven |
| dif_t | output | N_OUT | True output levels |
| dif_t_en | output | N_OUT | True output drive enables |
| dif_c | output | N_OUT | Complement output levels |
| dif_c_en | output | N_OUT | Complement output drive enables |

## Verification
Some properties are checked on every cycle. An undriven wire must read low. A driven complement must be the exact inverse of its true wire. A parked output must hold still. A free-running output must keep toggling once power-down has been released and its enable has been steady for a while. The bench scenarios cover what needs a whole sequence of stimulus. These are the rejection of one-cycle request pulses, the two parked drive styles for stop and for power-down, and the resume latency window with all outputs restarting in the same cycle. They also cover enable polarity under both strap values and strap changes made after reset.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;

  typedef struct packed {
    logic t;
    logic t_en;
    logic c;
    logic c_en;
  } pair_drv_t;

  localparam pair_drv_t DRV_RESET = '{t: 1'b0, t_en: 1'b1, c: 1'b1, c_en: 1'b1};

  // parked drive: mode 0 keeps true driven high, mode 1 releases everything
  function automatic pair_drv_t parked_drv(input logic mode);
    pair_drv_t d;
    d.t    = ~mode;
    d.t_en = ~mode;
    d.c    = 1'b0;
    d.c_en = 1'b0;
    return d;
  endfunction

  function automatic pair_drv_t running_drv(input logic lvl);
    pair_drv_t d;
    d.t    = lvl;
    d.t_en = 1'b1;
    d.c    = ~lvl;
    d.c_en = 1'b1;
    return d;
  endfunction

endpackage

// File: rtl/cg_debounce.sv
// Accepts a new input level only after two matching samples on strobe.
module cg_debounce #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  input  logic din,
  output logic dout
);
  logic prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= RST_VAL;
      dout <= RST_VAL;
    end else if (strobe) begin
      prev <= din;
      if (din == prev) dout <= din;
    end
  end
endmodule

// File: rtl/cg_ctrl.sv
// Output clock phase, request filtering, hold flags and release delay.
module cg_ctrl #(
  parameter int RESUME_PER = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic stop_n,
  input  logic pd_n,
  output logic ph,
  output logic stop_hold,
  output logic pd_hold
);
  localparam int LAT_CYC = 2 * RESUME_PER;
  localparam int CW      = $clog2(LAT_CYC + 1);
  localparam logic [CW-1:0] LAT_V = CW'(LAT_CYC);

  logic stop_f, pd_f;
  logic [CW-1:0] cnt;
  logic rel_pend, rel_done;

  // ph==1 means this edge takes true low: complement rising edge
  cg_debounce #(.RST_VAL(1'b1)) u_stop_db (
    .clk(clk), .rst(rst), .strobe(ph), .din(stop_n), .dout(stop_f));
  cg_debounce #(.RST_VAL(1'b1)) u_pd_db (
    .clk(clk), .rst(rst), .strobe(ph), .din(pd_n), .dout(pd_f));

  assign rel_pend = (stop_hold & stop_f) | (pd_hold & pd_f);
  assign rel_done = rel_pend && (cnt == LAT_V);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph        <= 1'b0;
      stop_hold <= 1'b0;
      pd_hold   <= 1'b0;
      cnt       <= '0;
    end else begin
      ph <= ~ph;
      if (!rel_pend)        cnt <= '0;
      else if (cnt != LAT_V) cnt <= cnt + 1'b1;
      if (!stop_f)               stop_hold <= 1'b1;
      else if (rel_done)         stop_hold <= 1'b0;
      if (!pd_f)                 pd_hold <= 1'b1;
      else if (rel_done)         pd_hold <= 1'b0;
    end
  end
endmodule

// File: rtl/cg_chan.sv
// One output pair: phase-aligned park and resume decisions, registered drive.
module cg_chan
  import clkgate_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      ph,
  input  logic      pd_hold,
  input  logic      stop_hold,
  input  logic      stoppable,
  input  logic      en_eff,
  input  logic      stop_mode,
  input  logic      pd_mode,
  output pair_drv_t drv
);
  logic park, sty;       // sty=1: parked in power-down style
  logic park_n, sty_n;
  logic al_run, al_stop, soft_want;

  assign al_run    = ~ph;               // next level of true is high
  assign al_stop   = (ph == stop_mode); // next level equals parked true level
  assign soft_want = (stop_hold & stoppable) | ~en_eff;

  always_comb begin
    park_n = park;
    sty_n  = sty;
    if (pd_hold) begin
      if (al_run) begin
        park_n = 1'b1;
        sty_n  = 1'b1;
      end
    end else if (soft_want) begin
      if (al_stop && (!park || sty)) begin
        park_n = 1'b1;
        sty_n  = 1'b0;
      end
    end else if (al_run) begin
      park_n = 1'b0;
      sty_n  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      park <= 1'b0;
      sty  <= 1'b0;
      drv  <= DRV_RESET;
    end else begin
      park <= park_n;
      sty  <= sty_n;
      if (!park_n)   drv <= running_drv(~ph);
      else if (sty_n) drv <= parked_drv(pd_mode);
      else           drv <= parked_drv(stop_mode);
    end
  end
endmodule

// File: rtl/diff_clk_gate.sv
module diff_clk_gate
  import clkgate_pkg::*;
#(
  parameter int N_OUT      = 8,
  parameter int RESUME_PER = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             oe_pol_strap,
  input  logic [N_OUT-1:0] oe_in,
  input  logic             stop_n,
  input  logic             pd_n,
  input  logic [N_OUT-1:0] stop_en,
  input  logic             stop_mode,
  input  logic             pd_mode,
  output logic [N_OUT-1:0] dif_t,
  output logic [N_OUT-1:0] dif_t_en,
  output logic [N_OUT-1:0] dif_c,
  output logic [N_OUT-1:0] dif_c_en
);
  logic ph, stop_hold, pd_hold;
  logic strap_q;
  logic [N_OUT-1:0] en_eff;

  always_ff @(posedge clk) begin
    if (rst) strap_q <= oe_pol_strap;
  end

  assign en_eff = oe_in ^ {N_OUT{strap_q}};

  cg_ctrl #(.RESUME_PER(RESUME_PER)) u_ctrl (
    .clk(clk), .rst(rst), .stop_n(stop_n), .pd_n(pd_n),
    .ph(ph), .stop_hold(stop_hold), .pd_hold(pd_hold));

  for (genvar g = 0; g < N_OUT; g++) begin : g_ch
    pair_drv_t drv;
    cg_chan u_chan (
      .clk(clk), .rst(rst), .ph(ph), .pd_hold(pd_hold),
      .stop_hold(stop_hold), .stoppable(stop_en[g]), .en_eff(en_eff[g]),
      .stop_mode(stop_mode), .pd_mode(pd_mode), .drv(drv));
    assign dif_t[g]    = drv.t;
    assign dif_t_en[g] = drv.t_en;
    assign dif_c[g]    = drv.c;
    assign dif_c_en[g] = drv.c_en;
  end
endmodule

// File: rtl/cg_chk.sv
module cg_chk #(
  parameter int N_OUT = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             oe_pol_strap,
  input logic [N_OUT-1:0] oe_in,
  input logic             pd_n,
  input logic [N_OUT-1:0] stop_en,
  input logic [N_OUT-1:0] dif_t,
  input logic [N_OUT-1:0] dif_t_en,
  input logic [N_OUT-1:0] dif_c,
  input logic [N_OUT-1:0] dif_c_en
);
  localparam int CALM = 24;
  logic strap_cap;
  logic [5:0] calm;
  logic [N_OUT-1:0] en_now, en_last, stop_en_last;

  assign en_now = oe_in ^ {N_OUT{strap_cap}};

  always_ff @(posedge clk) begin
    if (rst) begin
      strap_cap    <= oe_pol_strap;
      calm         <= '0;
      en_last      <= '0;
      stop_en_last <= '0;
    end else begin
      en_last      <= en_now;
      stop_en_last <= stop_en;
      if (!pd_n || en_now != en_last || stop_en != stop_en_last) calm <= '0;
      else if (calm != 6'd63) calm <= calm + 1'b1;
    end
  end

  for (genvar i = 0; i < N_OUT; i++) begin : g_a
    // R12
    undriven_low_chk: assert property (@(posedge clk) disable iff (rst)
      (!dif_t_en[i] |-> !dif_t[i]) and (!dif_c_en[i] |-> !dif_c[i]));
    // R12
    comp_pair_chk: assert property (@(posedge clk) disable iff (rst)
      dif_c_en[i] |-> (dif_t_en[i] && dif_c[i] == !dif_t[i]));
    // R3
    parked_still_chk: assert property (@(posedge clk) disable iff (rst)
      (!dif_c_en[i] && $past(!dif_c_en[i])) |-> ($stable(dif_t[i]) && $stable(dif_t_en[i])));
    // R5
    free_run_chk: assert property (@(posedge clk) disable iff (rst)
      (!stop_en[i] && en_now[i] && calm >= 6'(CALM)) |-> (dif_t[i] != $past(dif_t[i])));
  end
endmodule

bind diff_clk_gate cg_chk #(.N_OUT(N_OUT)) u_cg_chk (
  .clk(clk), .rst(rst), .oe_pol_strap(oe_pol_strap), .oe_in(oe_in),
  .pd_n(pd_n), .stop_en(stop_en), .dif_t(dif_t), .dif_t_en(dif_t_en),
  .dif_c(dif_c), .dif_c_en(dif_c_en));

// File: tb/diff_clk_gate_test.sv
module diff_clk_gate_test;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic oe_pol_strap = 1'b0;
  logic [N-1:0] oe_in = '1;
  logic stop_n = 1'b1;
  logic pd_n = 1'b1;
  logic [N-1:0] stop_en = 8'h0F;
  logic stop_mode = 1'b0;
  logic pd_mode = 1'b0;
  logic [N-1:0] dif_t, dif_t_en, dif_c, dif_c_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  diff_clk_gate uut (
    .clk(clk), .rst(rst), .oe_pol_strap(oe_pol_strap), .oe_in(oe_in),
    .stop_n(stop_n), .pd_n(pd_n), .stop_en(stop_en), .stop_mode(stop_mode),
    .pd_mode(pd_mode), .dif_t(dif_t), .dif_t_en(dif_t_en), .dif_c(dif_c),
    .dif_c_en(dif_c_en));

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic watch(input int n, output logic [N-1:0] tog);
    logic [N-1:0] prev;
    tog  = '0;
    prev = dif_t;
    repeat (n) begin
      @(negedge clk);
      tog  |= dif_t ^ prev;
      prev  = dif_t;
    end
  endtask

  task automatic do_reset(input logic strap);
    rst = 1'b1;
    oe_pol_strap = strap;
    cyc(3);
    // R1 reset drive
    chk(dif_t == 8'h00, "R1 t", dif_t, 8'h00);
    chk(dif_c == 8'hFF && dif_t_en == 8'hFF && dif_c_en == 8'hFF, "R1 drive", dif_c_en, 8'hFF);
    rst = 1'b0;
  endtask

  task automatic t_run;
    logic [N-1:0] tog;
    watch(6, tog);
    chk(tog == 8'hFF, "R1 toggle", tog, 8'hFF);
    chk(dif_c == ~dif_t, "R1 complement", dif_c, ~dif_t);
  endtask

  task automatic t_stop(input logic mode);
    logic [N-1:0] tog;
    int lat;
    stop_mode = mode;
    stop_n = 1'b0;
    cyc(12);
    watch(6, tog);
    chk(tog == 8'hF0, "R5 free outputs run, stoppable halt", tog, 8'hF0);
    if (!mode) begin
      chk(dif_t[3:0] == 4'hF && dif_t_en[3:0] == 4'hF, "R3 true high driven", {dif_t[3:0], dif_t_en[3:0]}, 8'hFF);
      chk(dif_c[3:0] == 4'h0 && dif_c_en[3:0] == 4'h0, "R3 R12 complement undriven low", {dif_c[3:0], dif_c_en[3:0]}, 8'h00);
    end else begin
      chk({dif_t[3:0], dif_t_en[3:0]} == 8'h00, "R4 true undriven low", {dif_t[3:0], dif_t_en[3:0]}, 8'h00);
      chk({dif_c[3:0], dif_c_en[3:0]} == 8'h00, "R4 complement undriven low", {dif_c[3:0], dif_c_en[3:0]}, 8'h00);
    end
    stop_n = 1'b1;
    lat = 0;
    while (dif_c_en[3:0] == 4'h0 && lat < 40) begin
      cyc(1);
      lat++;
    end
    chk(dif_c_en[3:0] == 4'hF, "R6 all resume together", {4'h0, dif_c_en[3:0]}, 8'h0F);
    chk(lat >= 6 && lat <= 16, "R6 resume latency", 8'(lat), 8'd12);
    watch(6, tog);
    chk(tog == 8'hFF, "R6 running after resume", tog, 8'hFF);
  endtask

  task automatic t_stop_glitch;
    logic [N-1:0] tog;
    stop_mode = 1'b0;
    stop_n = 1'b0;
    cyc(1);
    stop_n = 1'b1;
    watch(20, tog);
    chk(tog == 8'hFF && dif_c_en == 8'hFF, "R2 short stop ignored", tog & dif_c_en, 8'hFF);
  endtask

  task automatic t_pd(input logic mode);
    logic [N-1:0] tog;
    pd_mode = mode;
    pd_n = 1'b0;
    cyc(12);
    watch(6, tog);
    chk(tog == 8'h00, "R7 all outputs parked", tog, 8'h00);
    if (!mode) begin
      chk(dif_t == 8'hFF && dif_t_en == 8'hFF, "R7 true high driven", dif_t & dif_t_en, 8'hFF);
      chk(dif_c_en == 8'h00 && dif_c == 8'h00, "R7 complement undriven", dif_c_en | dif_c, 8'h00);
    end else begin
      chk((dif_t | dif_t_en | dif_c | dif_c_en) == 8'h00, "R8 all undriven low",
          dif_t | dif_t_en | dif_c | dif_c_en, 8'h00);
    end
    pd_n = 1'b1;
    cyc(20);
    watch(6, tog);
    chk(tog == 8'hFF && dif_c_en == 8'hFF, "R9 resume after power-down", tog & dif_c_en, 8'hFF);
  endtask

  task automatic t_pd_glitch;
    logic [N-1:0] tog;
    pd_n = 1'b0;
    cyc(1);
    pd_n = 1'b1;
    watch(20, tog);
    chk(tog == 8'hFF && dif_c_en == 8'hFF, "R7 short power-down ignored", tog & dif_c_en, 8'hFF);
  endtask

  task automatic t_oe_high;
    logic [N-1:0] tog;
    stop_mode = 1'b0;
    oe_in = 8'hEF;
    cyc(8);
    watch(6, tog);
    chk(tog == 8'hEF, "R10 active-high disable parks output 4", tog, 8'hEF);
    chk({dif_t[4], dif_t_en[4], dif_c[4], dif_c_en[4]} == 4'b1100, "R10 disabled stop style",
        {4'h0, dif_t[4], dif_t_en[4], dif_c[4], dif_c_en[4]}, 8'h0C);
    oe_in = 8'hFF;
    cyc(4);
    watch(6, tog);
    chk(tog == 8'hFF, "R10 re-enable", tog, 8'hFF);
  endtask

  task automatic t_strap;
    logic [N-1:0] tog;
    oe_in = 8'h00;
    do_reset(1'b1);
    watch(6, tog);
    chk(tog == 8'hFF, "R10 active-low enables all on", tog, 8'hFF);
    oe_pol_strap = 1'b0;
    watch(10, tog);
    chk(tog == 8'hFF, "R11 strap change after reset ignored", tog, 8'hFF);
    stop_mode = 1'b1;
    oe_in = 8'h01;
    cyc(8);
    watch(6, tog);
    chk(tog == 8'hFE, "R10 active-low disable of output 0", tog, 8'hFE);
    chk({dif_t[0], dif_t_en[0], dif_c[0], dif_c_en[0]} == 4'b0000, "R10 disabled undriven",
        {4'h0, dif_t[0], dif_t_en[0], dif_c[0], dif_c_en[0]}, 8'h00);
  endtask

  initial begin
    do_reset(1'b0);
    t_run();
    t_stop(1'b0);
    t_stop(1'b1);
    t_stop_glitch();
    t_pd(1'b0);
    t_pd(1'b1);
    t_pd_glitch();
    t_oe_high();
    t_strap();
    done = 1'b1;
  end

  initial begin
    int n;
    n = 0;
    while (!done && n < 20000) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=done", n);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule